// File: doc/BRIEF.md
# Auto-Incrementing Memory Access Window

This block lets a host reach an internal memory of 32-bit words, and a bank of internal peripheral registers, through a small window of host registers. For the memory the host sets a read pointer or a write pointer once. It then moves a run of consecutive words through a data register. After every data access the pointer involved steps on by one dword. The read pointer and the write pointer are separate, so a read stream and a write stream can be interleaved.

Writing the read pointer starts a fetch of the first word at once. Every read of the read-data register starts the fetch of the next word. As a result, a data read returns its word on the following cycle, even when it comes directly after the address write. The memory is a synchronous single-port RAM outside the block.

The peripheral side has its own pair of address registers. Each holds a 16-bit register offset and a two-bit byte count minus one. The byte count sets the byte enables from the lowest lane upward and trims the read data. Peripheral addresses stay where they are after a data access.

Top module: `mem_window`

## Requirements
- R1: After reset, both memory pointers and both peripheral address registers read back as zero, host_rdata is zero, and neither mem_en nor per_en is raised while the host only reads address registers.
- R2: A host write of offset 0x0C loads the read pointer and, in the same cycle, raises mem_en with mem_we low and mem_addr equal to bits MEM_AW+1:2 of the written value; reading offset 0x0C returns the pointer.
- R3: A host read of offset 0x1C returns, on host_rdata in the cycle after the access, the memory word at the read pointer, including when it immediately follows the pointer write.
- R4: Each read of offset 0x1C advances the read pointer by 4 and fetches the following word in the same cycle, so back-to-back reads return consecutive words.
- R5: A host write of offset 0x18 writes host_wdata to the memory word at the write pointer (mem_en and mem_we high in that cycle) and advances the write pointer by 4. Writing offset 0x10 loads the write pointer without a memory access.
- R6: The low two pointer bits never reach mem_addr; they are kept in the pointer and read back, and advancing adds 4 to the full 32-bit value.
- R7: Accesses through one memory pointer leave the other pointer and its stream untouched.
- R8: Peripheral write address (0x44) and read address (0x48) keep the offset in bits 15:0 and the byte count minus one in bits 25:24; all other bits read back as zero, and data accesses do not change them.
- R9: A host write of offset 0x4C raises per_en and per_we, and drives per_addr from the write-address register and per_wdata from host_wdata. per_be has the lowest count+1 lanes set: count 0 gives 0001, 1 gives 0011, 2 gives 0111 and 3 gives 1111.
- R10: Writing offset 0x48 fetches the addressed peripheral register at once. A read of offset 0x50 returns that value with the byte lanes above the count forced to zero, and fetches the same register again.
- R11: Offsets outside the eight above read as zero, and writes to them raise neither mem_en nor per_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe (wins over host_rd) |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | WIN_AW | Byte offset within the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid the cycle after host_rd |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| per_en | output | 1 | Peripheral access enable |
| per_we | output | 1 | Peripheral write enable |
| per_addr | output | PER_AW | Peripheral register offset |
| per_be | output | 4 | Peripheral byte enables |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, one cycle after a read |

## Verification
The hardest case is a data read in the cycle right after the read-address write. Here the word is still on the memory output and not yet in the holding register. The bench makes this happen by issuing the address write and then a run of reads on successive clock edges. It then inserts an idle gap before one further read, so that the held copy is also used. Interleaved read and write streams check that the two pointers stay independent. Each of the four byte counts is driven through the peripheral path to check the lane patterns and the read-data trimming.

// File: rtl/mem_window.sv
module mem_window #(
  parameter int MEM_AW = 10,
  parameter int WIN_AW = 8,
  parameter int PER_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [WIN_AW-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              per_en,
  output logic              per_we,
  output logic [PER_AW-1:0] per_addr,
  output logic [3:0]        per_be,
  output logic [31:0]       per_wdata,
  input  logic [31:0]       per_rdata
);
  localparam logic [WIN_AW-1:0] OFF_MRA = WIN_AW'(8'h0C);
  localparam logic [WIN_AW-1:0] OFF_MWA = WIN_AW'(8'h10);
  localparam logic [WIN_AW-1:0] OFF_MWD = WIN_AW'(8'h18);
  localparam logic [WIN_AW-1:0] OFF_MRD = WIN_AW'(8'h1C);
  localparam logic [WIN_AW-1:0] OFF_PWA = WIN_AW'(8'h44);
  localparam logic [WIN_AW-1:0] OFF_PRA = WIN_AW'(8'h48);
  localparam logic [WIN_AW-1:0] OFF_PWD = WIN_AW'(8'h4C);
  localparam logic [WIN_AW-1:0] OFF_PRD = WIN_AW'(8'h50);

  function automatic logic [3:0] lanes(input logic [1:0] cnt);
    logic [4:0] t;
    t = (5'd2 << cnt) - 5'd1;
    return t[3:0];
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  logic [31:0]       rptr, wptr, mbuf, pbuf, rdsel;
  logic [PER_AW-1:0] pw_off, pr_off;
  logic [1:0]        pw_cnt, pr_cnt;
  logic              mpend, ppend, rd;
  logic              wr_mra, wr_mwa, wr_mwd, rd_mrd;
  logic              wr_pwa, wr_pra, wr_pwd, rd_prd;

  assign rd     = host_rd & ~host_wr;
  assign wr_mra = host_wr & (host_addr == OFF_MRA);
  assign wr_mwa = host_wr & (host_addr == OFF_MWA);
  assign wr_mwd = host_wr & (host_addr == OFF_MWD);
  assign rd_mrd = rd      & (host_addr == OFF_MRD);
  assign wr_pwa = host_wr & (host_addr == OFF_PWA);
  assign wr_pra = host_wr & (host_addr == OFF_PRA);
  assign wr_pwd = host_wr & (host_addr == OFF_PWD);
  assign rd_prd = rd      & (host_addr == OFF_PRD);

  assign mem_en    = wr_mra | rd_mrd | wr_mwd;
  assign mem_we    = wr_mwd;
  assign mem_wdata = host_wdata;
  assign mem_addr  = wr_mra ? host_wdata[MEM_AW+1:2] :
                     rd_mrd ? rptr[MEM_AW+1:2] + MEM_AW'(1) :
                              wptr[MEM_AW+1:2];

  assign per_en    = wr_pra | rd_prd | wr_pwd;
  assign per_we    = wr_pwd;
  assign per_wdata = host_wdata;
  assign per_addr  = wr_pra ? host_wdata[PER_AW-1:0] : wr_pwd ? pw_off : pr_off;
  assign per_be    = wr_pra ? lanes(host_wdata[25:24]) : wr_pwd ? lanes(pw_cnt) : lanes(pr_cnt);

  always_comb begin
    unique case (host_addr)
      OFF_MRA: rdsel = rptr;
      OFF_MWA: rdsel = wptr;
      OFF_MRD: rdsel = mpend ? mem_rdata : mbuf;
      OFF_PWA: rdsel = 32'(pw_off) | (32'(pw_cnt) << 24);
      OFF_PRA: rdsel = 32'(pr_off) | (32'(pr_cnt) << 24);
      OFF_PRD: rdsel = (ppend ? per_rdata : pbuf) & lane_mask(lanes(pr_cnt));
      default: rdsel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr       <= '0;
      wptr       <= '0;
      mbuf       <= '0;
      pbuf       <= '0;
      mpend      <= 1'b0;
      ppend      <= 1'b0;
      pw_off     <= '0;
      pr_off     <= '0;
      pw_cnt     <= '0;
      pr_cnt     <= '0;
      host_rdata <= '0;
    end else begin
      mpend <= wr_mra | rd_mrd;
      ppend <= wr_pra | rd_prd;
      if (mpend) mbuf <= mem_rdata;
      if (ppend) pbuf <= per_rdata;
      if (wr_mra)      rptr <= host_wdata;
      else if (rd_mrd) rptr <= rptr + 32'd4;
      if (wr_mwa)      wptr <= host_wdata;
      else if (wr_mwd) wptr <= wptr + 32'd4;
      if (wr_pwa) begin
        pw_off <= host_wdata[PER_AW-1:0];
        pw_cnt <= host_wdata[25:24];
      end
      if (wr_pra) begin
        pr_off <= host_wdata[PER_AW-1:0];
        pr_cnt <= host_wdata[25:24];
      end
      if (rd) host_rdata <= rdsel;
    end
  end
endmodule

// File: rtl/mem_window_chk.sv
module mem_window_chk #(
  parameter int MEM_AW = 10,
  parameter int WIN_AW = 8,
  parameter int PER_AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [WIN_AW-1:0] host_addr,
  input logic [31:0]       host_wdata,
  input logic              mem_en,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              per_en,
  input logic              per_we,
  input logic [PER_AW-1:0] per_addr,
  input logic [3:0]        per_be
);
  logic c_mra, c_mwd, c_mrd, c_pwd;
  assign c_mra = host_wr && host_addr == WIN_AW'(8'h0C);
  assign c_mwd = host_wr && host_addr == WIN_AW'(8'h18);
  assign c_mrd = host_rd && !host_wr && host_addr == WIN_AW'(8'h1C);
  assign c_pwd = host_wr && host_addr == WIN_AW'(8'h4C);

  AST_RADDR_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    c_mra |-> mem_en && !mem_we && mem_addr == host_wdata[MEM_AW+1:2]); // R2
  AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mrd && $past(c_mrd)) |-> mem_addr == $past(mem_addr) + MEM_AW'(1)); // R4
  AST_WDATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    c_mwd |-> mem_en && mem_we); // R5
  AST_PADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pwd && $past(c_pwd)) |-> per_addr == $past(per_addr)); // R8
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> per_be[0] && ((per_be & (per_be + 4'd1)) == 4'd0)); // R9
  AST_NO_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr || host_rd) |-> !mem_en && !per_en); // R11
endmodule

bind mem_window mem_window_chk #(.MEM_AW(MEM_AW), .WIN_AW(WIN_AW), .PER_AW(PER_AW)) u_chk (.*);

// File: tb/mem_window_bench.sv
module mem_window_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mem_en, mem_we, per_en, per_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, per_wdata, per_rdata;
  logic [15:0] per_addr;
  logic [3:0]  per_be;

  int nchk = 0, nerr = 0;
  logic        s_mem_en, s_mem_we, s_per_en, s_per_we;
  logic [MEM_AW-1:0] s_mem_addr;
  logic [15:0] s_per_addr;
  logic [3:0]  s_per_be;
  logic [31:0] s_per_wdata;

  logic [31:0] mem [1<<MEM_AW];
  logic [31:0] preg [64];
  logic [31:0] mem_q = '0, per_q = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_window u_mem_window (
    .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .per_en, .per_we, .per_addr, .per_be, .per_wdata, .per_rdata
  );

  function automatic logic [31:0] memf(input int i);
    return 32'h5A00_0000 | (32'(i) * 32'd7);
  endfunction

  assign mem_rdata = mem_q;
  assign per_rdata = per_q;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_q <= mem[mem_addr];
    end
    if (per_en) begin
      if (per_we) begin
        for (int b = 0; b < 4; b++)
          if (per_be[b]) preg[per_addr[7:2]][b*8 +: 8] <= per_wdata[b*8 +: 8];
      end else per_q <= preg[per_addr[7:2]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_mem_en = mem_en; s_mem_we = mem_we; s_mem_addr = mem_addr;
    s_per_en = per_en; s_per_we = per_we; s_per_addr = per_addr;
    s_per_be = per_be; s_per_wdata = per_wdata;
  endtask

  task automatic hwrite(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = off; host_wdata = d;
    #1 snap();
    @(posedge clk);
    #1 host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = off;
    #1 snap();
    @(posedge clk);
    #1 host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rdata after reset", host_rdata, 32'h0);
    hread(8'h0C, v); chk("R1 read pointer", v, 32'h0);
    chk("R1 no mem access", 32'(s_mem_en), 32'h0);
    hread(8'h10, v); chk("R1 write pointer", v, 32'h0);
    hread(8'h44, v); chk("R1 periph wr addr", v, 32'h0);
    hread(8'h48, v); chk("R1 periph rd addr", v, 32'h0);
    chk("R1 no periph access", 32'(s_per_en), 32'h0);
  endtask

  task automatic t_read_stream();
    logic [31:0] v;
    hwrite(8'h0C, 32'h100);
    chk("R2 fetch enable", {s_mem_en, s_mem_we}, 32'h2);
    chk("R2 fetch addr", 32'(s_mem_addr), 32'h40);
    for (int k = 0; k < 4; k++) begin
      hread(8'h1C, v);
      chk(k == 0 ? "R3 first word no stall" : "R4 streamed word", v, memf(32'h40 + k));
    end
    hread(8'h0C, v); chk("R4 pointer advanced", v, 32'h110);
    repeat (3) @(posedge clk);
    hread(8'h1C, v); chk("R3 word after idle gap", v, memf(32'h44));
  endtask

  task automatic t_write_stream();
    logic [31:0] v;
    hwrite(8'h10, 32'h203);
    chk("R5 addr write no access", 32'(s_mem_en), 32'h0);
    for (int k = 0; k < 3; k++) begin
      hwrite(8'h18, 32'hC0DE_0000 + k);
      chk("R5 write enables", {s_mem_en, s_mem_we}, 32'h3);
      chk("R6 write word addr", 32'(s_mem_addr), 32'h80 + k);
    end
    hread(8'h10, v); chk("R6 pointer keeps low bits", v, 32'h20F);
    hwrite(8'h0C, 32'h202);
    chk("R6 read word addr", 32'(s_mem_addr), 32'h80);
    for (int k = 0; k < 3; k++) begin
      hread(8'h1C, v); chk("R5 written word", v, 32'hC0DE_0000 + k);
    end
  endtask

  task automatic t_interleave();
    logic [31:0] v;
    hwrite(8'h0C, 32'h40);
    hwrite(8'h10, 32'h300);
    for (int k = 0; k < 3; k++) begin
      hwrite(8'h18, 32'hBEE0_0000 + k);
      chk("R7 write addr", 32'(s_mem_addr), 32'hC0 + k);
      hread(8'h1C, v);
      chk("R7 read word", v, memf(32'h10 + k));
    end
    hread(8'h0C, v); chk("R7 read pointer", v, 32'h4C);
    hread(8'h10, v); chk("R7 write pointer", v, 32'h30C);
    chk("R7 memory content", mem[32'hC1], 32'hBEE0_0001);
  endtask

  task automatic t_periph();
    logic [31:0] v;
    logic [3:0] exp_be [4] = '{4'b0001, 4'b0011, 4'b0111, 4'b1111};
    for (int c = 0; c < 4; c++) begin
      hwrite(8'h44, 32'hFC7F_0000 | (32'(c) << 24) | 32'h10);
      hread(8'h44, v); chk("R8 masked readback", v, (32'(c) << 24) | 32'h10);
      hwrite(8'h4C, 32'h1122_3344 + c);
      chk("R9 write enables", {s_per_en, s_per_we}, 32'h3);
      chk("R9 byte enables", 32'(s_per_be), 32'(exp_be[c]));
      chk("R9 periph addr", 32'(s_per_addr), 32'h10);
      chk("R9 periph data", s_per_wdata, 32'h1122_3344 + c);
      hwrite(8'h4C, 32'h0);
      chk("R8 addr held", 32'(s_per_addr), 32'h10);
      hread(8'h44, v); chk("R8 not advanced", v, (32'(c) << 24) | 32'h10);
    end
    hwrite(8'h44, (32'd3 << 24) | 32'h20);
    hwrite(8'h4C, 32'hDEAD_BEEF);
    hwrite(8'h48, (32'd1 << 24) | 32'h20);
    chk("R10 fetch enables", {s_per_en, s_per_we}, 32'h2);
    chk("R10 fetch addr", 32'(s_per_addr), 32'h20);
    hread(8'h50, v); chk("R10 trimmed data", v, 32'h0000_BEEF);
    chk("R10 refetch same addr", 32'(s_per_addr), 32'h20);
    hread(8'h50, v); chk("R10 repeat read", v, 32'h0000_BEEF);
    hwrite(8'h48, (32'd2 << 24) | 32'h20);
    hread(8'h50, v); chk("R10 three lanes", v, 32'h00AD_BEEF);
    hwrite(8'h48, (32'd3 << 24) | 32'h20);
    hread(8'h50, v); chk("R10 full dword", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    hwrite(8'h30, 32'hFFFF_FFFF);
    chk("R11 no access on unmapped write", {s_mem_en, s_per_en}, 32'h0);
    hread(8'h30, v); chk("R11 unmapped reads zero", v, 32'h0);
    hread(8'h10, v); chk("R11 pointer untouched", v, 32'h30C);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < (1 << MEM_AW); i++) mem[i] = memf(i);
    for (int i = 0; i < 64; i++) preg[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_stream();
    t_write_stream();
    t_interleave();
    t_periph();
    t_unmapped();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule